// File: doc/BRIEF.md
# Random Slot Delay Generator

This block picks the transmit slot for a tag that takes part in framed slotted ALOHA anti-collision. When told to start, it seeds a 16-bit maximal-length LFSR from the tag's stored checksum word. It then steps the register for a warm-up period whose length comes from the low byte of the tag identifier. After the warm-up it keeps stepping, once per clock, until the first 0 bit of an incoming command appears on the serial input. The register is frozen at that moment, and its value is loaded into a slot down-counter.

The counter moves down by one on each slot tick. When it has reached zero, the block raises a single-cycle `slot_expired` pulse, which grants the tag its transmit opportunity. The block then returns to idle. Because the warm-up length and the arrival time of the command both change the final value, tags that share a seed still spread across different slots. A synchronous clear abandons a selection at any point.

Top module: `slot_delay_gen`

## Requirements
- R1: After `rst` or a cycle with `clr` high, `busy` and `slot_expired` are 0 from the next clock on, and no `slot_expired` pulse follows until a new start is accepted.
- R2: On an accepted start the LFSR takes `seed`. A `seed` of all zeros is replaced by 16'h0001, so the loaded slot count is never 0.
- R3: One LFSR step shifts the register left by one bit and inserts bit 15 ^ bit 13 ^ bit 12 ^ bit 10 at bit 0 (polynomial x^16+x^14+x^13+x^11+1).
- R4: Warm-up performs exactly `tag_id[7:0]` steps on the clocks after the start clock, plus one further clock with no step. During warm-up, 0 bits on `rx_bit` are ignored.
- R5: After warm-up, the LFSR steps on every clock unless `rx_valid` is 1 and `rx_bit` is 0. On that clock it does not step, and its value is loaded into the slot counter. A cycle with `rx_valid` at 0 counts as no command bit, whatever `rx_bit` holds.
- R6: While counting, the slot counter decreases by one on each clock with `slot_tick` high and holds otherwise. A loaded value of L therefore needs exactly L ticks to reach zero.
- R7: On the first clock after the counter has reached zero, `slot_expired` is high for exactly one cycle.
- R8: `busy` rises on the clock that accepts a start (start while idle), stays high throughout, and falls on the clock where `slot_expired` rises.
- R9: `start` while `busy` is high has no effect on the selection in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear back to idle |
| start | input | 1 | Begin a slot selection (accepted only while idle) |
| seed | input | 16 | Stored checksum used as LFSR seed |
| tag_id | input | 64 | Stored tag identifier; low byte sets warm-up length |
| rx_valid | input | 1 | A serial command bit is present this cycle |
| rx_bit | input | 1 | Serial command bit value |
| slot_tick | input | 1 | One pulse per slot period |
| slot_expired | output | 1 | One-cycle pulse when the chosen slot arrives |
| busy | output | 1 | Selection in progress |

## Verification
An all-zero seed with zero warm-up must give a slot count of exactly one. A design without the lockup guard would load zero and expire at once, or never move. Zero bits sent during warm-up must not stop the run: a design that reacts to them yields a different count. In the same way, `rx_bit` at 0 with `rx_valid` low must still count as a stepping cycle. Slow, gapped ticks, a start pulse in the middle of counting, and a clear in the middle of counting are used to show any early, late, repeated or stray expiry pulse.

// File: rtl/slot_pkg.sv
package slot_pkg;

    localparam int unsigned LFSR_W = 16;
    localparam int unsigned RUN_W  = 8;
    localparam int unsigned ID_W   = 64;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WARM  = 2'd1,
        ST_HUNT  = 2'd2,
        ST_COUNT = 2'd3
    } slot_state_e;

    typedef struct packed {
        logic lfsr_load;
        logic lfsr_step;
        logic cnt_load;
        logic cnt_en;
    } slot_ctl_t;

    // x^16 + x^14 + x^13 + x^11 + 1, left-shifting Fibonacci form
    function automatic logic [LFSR_W-1:0] lfsr_advance(input logic [LFSR_W-1:0] cur);
        logic fb;
        fb = cur[15] ^ cur[13] ^ cur[12] ^ cur[10];
        return {cur[LFSR_W-2:0], fb};
    endfunction

    function automatic logic [LFSR_W-1:0] seed_guard(input logic [LFSR_W-1:0] s);
        return (s == '0) ? {{(LFSR_W-1){1'b0}}, 1'b1} : s;
    endfunction

endpackage

// File: rtl/slot_lfsr.sv
module slot_lfsr
    import slot_pkg::*;
#(
    parameter int unsigned W = LFSR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] seed,
    output logic [W-1:0] value
);
    logic [W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= {{(W-1){1'b0}}, 1'b1};
        end else if (load) begin
            state_q <= seed_guard(seed);
        end else if (step) begin
            state_q <= lfsr_advance(state_q);
        end
    end

    assign value = state_q;

    // R2: the register never holds the lockup value
    a_r2_nonzero: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);

    // R3: a step with no load moves the previous value one place left
    a_r3_shift: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (state_q[W-1:1] == $past(state_q[W-2:0])));

endmodule

// File: rtl/slot_downcnt.sv
module slot_downcnt
    import slot_pkg::*;
#(
    parameter int unsigned W = LFSR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         en,
    input  logic         tick,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (en && tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

    // R6: without load or tick the count holds
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (!clr && !load && !(en && tick)) |=> $stable(cnt_q));

    // R6: an enabled tick on a nonzero count takes exactly one off
    a_r6_step: assert property (@(posedge clk) disable iff (rst)
        (!clr && !load && en && tick && !zero) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/slot_ctrl.sv
module slot_ctrl
    import slot_pkg::*;
#(
    parameter int unsigned RW = RUN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          start,
    input  logic [RW-1:0] run_len,
    input  logic          rx_valid,
    input  logic          rx_bit,
    input  logic          cnt_zero,
    output slot_ctl_t     ctl,
    output logic          expired,
    output logic          busy
);
    slot_state_e   state_q, state_d;
    logic [RW-1:0] run_q, run_d;
    logic          expire_d;
    logic          zero_bit;

    assign zero_bit = rx_valid && !rx_bit;

    always_comb begin
        state_d  = state_q;
        run_d    = run_q;
        ctl      = '0;
        expire_d = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    ctl.lfsr_load = 1'b1;
                    run_d         = run_len;
                    state_d       = ST_WARM;
                end
            end
            ST_WARM: begin
                if (run_q == '0) begin
                    state_d = ST_HUNT;
                end else begin
                    ctl.lfsr_step = 1'b1;
                    run_d         = run_q - 1'b1;
                end
            end
            ST_HUNT: begin
                if (zero_bit) begin
                    ctl.cnt_load = 1'b1;
                    state_d      = ST_COUNT;
                end else begin
                    ctl.lfsr_step = 1'b1;
                end
            end
            ST_COUNT: begin
                if (cnt_zero) begin
                    expire_d = 1'b1;
                    state_d  = ST_IDLE;
                end else begin
                    ctl.cnt_en = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (clr) begin
            ctl      = '0;
            expire_d = 1'b0;
            state_d  = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            run_q   <= '0;
            expired <= 1'b0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
            expired <= expire_d;
        end
    end

    assign busy = (state_q != ST_IDLE);

    // R1: clear forces idle
    a_r1_clear_idle: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!busy && !expired));

    // R7: the expiry pulse lasts one cycle
    a_r7_one_pulse: assert property (@(posedge clk) disable iff (rst)
        expired |=> !expired);

    // R8: an accepted start makes the block busy
    a_r8_busy_rise: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && !clr) |=> busy);

    // R8: busy drops together with the expiry pulse
    a_r8_busy_fall: assert property (@(posedge clk) disable iff (rst)
        expired |-> !busy);

    // R9: a start while counting does not restart the seed load
    a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |-> !ctl.lfsr_load);

endmodule

// File: rtl/slot_delay_gen.sv
module slot_delay_gen
    import slot_pkg::*;
#(
    parameter int unsigned SEED_W = LFSR_W,
    parameter int unsigned TID_W  = ID_W,
    parameter int unsigned WARM_W = RUN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              start,
    input  logic [SEED_W-1:0] seed,
    input  logic [TID_W-1:0]  tag_id,
    input  logic              rx_valid,
    input  logic              rx_bit,
    input  logic              slot_tick,
    output logic              slot_expired,
    output logic              busy
);
    slot_ctl_t         ctl;
    logic [SEED_W-1:0] rnd_val;
    logic              cnt_zero;

    slot_ctrl #(.RW(WARM_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .start    (start),
        .run_len  (tag_id[WARM_W-1:0]),
        .rx_valid (rx_valid),
        .rx_bit   (rx_bit),
        .cnt_zero (cnt_zero),
        .ctl      (ctl),
        .expired  (slot_expired),
        .busy     (busy)
    );

    slot_lfsr #(.W(SEED_W)) u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .load  (ctl.lfsr_load),
        .step  (ctl.lfsr_step),
        .seed  (seed),
        .value (rnd_val)
    );

    slot_downcnt #(.W(SEED_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .load     (ctl.cnt_load),
        .load_val (rnd_val),
        .en       (ctl.cnt_en),
        .tick     (slot_tick),
        .zero     (cnt_zero)
    );

endmodule

// File: tb/slot_delay_gen_test.sv
module slot_delay_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst, clr, start, rx_valid, rx_bit, slot_tick;
    logic [15:0] seed;
    logic [63:0] tag_id;
    logic        slot_expired, busy;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    int exp_q[$];
    int tick_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slot_delay_gen uut (
        .clk(clk), .rst(rst), .clr(clr), .start(start), .seed(seed),
        .tag_id(tag_id), .rx_valid(rx_valid), .rx_bit(rx_bit),
        .slot_tick(slot_tick), .slot_expired(slot_expired), .busy(busy)
    );

    task automatic chk(input string req, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Bench model of the register (R2, R3)
    function automatic int model_len(input logic [15:0] s0, input int steps);
        logic [15:0] s;
        s = (s0 == 16'h0) ? 16'h1 : s0;
        for (int i = 0; i < steps; i++)
            s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
        return int'(s);
    endfunction

    function automatic logic [15:0] pick_seed(input logic [15:0] base, input int steps);
        for (int k = 0; k < 65536; k++) begin
            if (model_len(base + 16'(k), steps) <= 1200) return base + 16'(k);
        end
        return base;
    endfunction

    // Monitor: ticks seen since the last accepted start
    always @(posedge clk) begin
        if (start && !busy) tick_seen <= 0;
        else if (slot_tick) tick_seen <= tick_seen + 1;
    end

    // Monitor: compare each expiry against the scoreboard
    always @(negedge clk) begin
        if (!rst && slot_expired) begin
            if (exp_q.size() == 0) begin
                chk("R1 unexpected expiry", 1, 0);
            end else begin
                chk("R6 ticks to expiry", tick_seen, exp_q.pop_front());
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // warm_zero: send 0 bits during warm-up (R4)
    // hunt_invalid: hunt-phase filler is rx_valid=0, rx_bit=0 (R5)
    task automatic select(input logic [15:0] s, input logic [63:0] id, input int ones,
                          input bit warm_zero, input bit hunt_invalid,
                          input bit gap, input bit poke_start);
        int n, len;
        n   = int'(id[7:0]);
        len = model_len(s, n + ones);
        exp_q.push_back(len);
        seed = s; tag_id = id;
        start = 1'b1;
        cyc(1);
        start = 1'b0;
        chk("R8 busy after start", int'(busy), 1);
        rx_valid = 1'b1; rx_bit = warm_zero ? 1'b0 : 1'b1;
        cyc(n + 1);
        if (hunt_invalid) begin rx_valid = 1'b0; rx_bit = 1'b0; end
        else              begin rx_valid = 1'b1; rx_bit = 1'b1; end
        cyc(ones);
        rx_valid = 1'b1; rx_bit = 1'b0;
        cyc(1);
        rx_valid = 1'b0; rx_bit = 1'b1;
        for (int i = 0; i < len - 1; i++) begin
            slot_tick = 1'b1;
            if (poke_start && i == 0) start = 1'b1;
            cyc(1);
            slot_tick = 1'b0; start = 1'b0;
            if (gap) cyc(1);
        end
        cyc(3);
        chk("R7 no early expiry", int'(slot_expired), 0);
        chk("R9 busy held", int'(busy), 1);
        slot_tick = 1'b1;
        cyc(1);
        slot_tick = 1'b0;
        chk("R7 not on zeroing clock", int'(slot_expired), 0);
        cyc(1);
        chk("R7 expiry pulse", int'(slot_expired), 1);
        chk("R8 busy falls", int'(busy), 0);
        cyc(1);
        chk("R7 single pulse", int'(slot_expired), 0);
        cyc(2);
    endtask

    initial begin
        rst = 1'b1; clr = 1'b0; start = 1'b0; rx_valid = 1'b0; rx_bit = 1'b1;
        slot_tick = 1'b0; seed = '0; tag_id = '0;
        cyc(3);
        rst = 1'b0;
        cyc(1);
        chk("R1 reset busy", int'(busy), 0);
        chk("R1 reset expired", int'(slot_expired), 0);

        // R2: zero seed, no warm-up, immediate zero bit -> count 1
        select(16'h0000, 64'h0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        // R3 R5: short warm-up, ones before zero
        select(pick_seed(16'h1234, 5 + 3), 64'hDEAD_BEEF_0000_0005, 3, 1'b0, 1'b0, 1'b0, 1'b0);
        // R4: zero bits during long warm-up must be ignored
        select(pick_seed(16'h8001, 200), 64'h0123_4567_89AB_CDC8, 0, 1'b1, 1'b0, 1'b0, 1'b0);
        // R5: invalid zero bits in hunt still step; R6 gapped ticks
        select(pick_seed(16'h4242, 17 + 6), 64'hFFFF_0000_FFFF_FF11, 6, 1'b0, 1'b1, 1'b1, 1'b0);
        // R9: start during counting
        select(pick_seed(16'hA5A5, 9 + 2), 64'h0000_0000_0000_0009, 2, 1'b0, 1'b0, 1'b0, 1'b1);

        // R1: clear during counting, then ticks cause nothing
        seed = 16'h0000; tag_id = 64'h3;
        start = 1'b1; cyc(1); start = 1'b0;
        rx_valid = 1'b1; rx_bit = 1'b0; cyc(5); rx_valid = 1'b0;
        slot_tick = 1'b1; cyc(1); slot_tick = 1'b0;
        clr = 1'b1; cyc(1); clr = 1'b0;
        chk("R1 clear busy", int'(busy), 0);
        slot_tick = 1'b1; cyc(40); slot_tick = 1'b0;
        chk("R1 idle after clear", int'(busy), 0);
        chk("R1 no pending expiry", exp_q.size(), 0);

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=0", WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule